// File: doc/BRIEF.md
# Multiplexed Address/Data SRAM Bus Master

This block runs single-byte read and write cycles against an external static RAM whose low address byte and data byte share one bidirectional 8-bit bus. An external transparent latch holds the low address while the latch-enable strobe is high. The RAM also sees a separately driven high-address byte and a page field. A client presents a 24-bit address, a write flag and a write byte on a one-cycle request. The block then runs a latch phase followed by a data phase and signals completion with a one-cycle done pulse. For reads it returns the byte it fetched.

The shared bus is brought out as three plain signals: an output byte, an output enable and an input byte. The pad ring or testbench resolves them into a real bidirectional net. The setup, pulse-width and hold lengths of each strobe are parameters, and so are the width and the mask of the page field.

Top module: `mux_sram_master`

## Requirements
- R1: After reset and whenever busy is low, the write strobe wr_n and the read strobe rd_n are 1 (both active low) and the latch strobe ale is 0 (active high).
- R2: Whenever busy is low, ad_oe is 0 (shared bus released), hi_addr is 0x00 and page is 0.
- R3: During an access, page carries address bits 23:16 ANDed with PAGE_MASK (width PAGE_W), hi_addr carries bits 15:8, and ad_out carries bits 7:0 during the latch phase. With the default mask 0x0F, addresses that differ only in bits 23:20 reach the same RAM location.
- R4: Each access first drives the address with ad_oe high for SETUP_CYC cycles. It then holds ale high for exactly PULSE_CYC cycles and keeps ale low with the address still driven for HOLD_CYC cycles, all before the data phase.
- R5: In a write, ad_out carries the write byte with ad_oe high for SETUP_CYC cycles. Then wr_n is low for exactly PULSE_CYC cycles and the byte stays driven for HOLD_CYC cycles after wr_n returns high.
- R6: In a read, ad_oe is 0 for SETUP_CYC turnaround cycles. Then rd_n is low for exactly PULSE_CYC cycles, ad_in is sampled on the last of those cycles, and the result appears on rd_data.
- R7: In the done cycle of every access, ad_oe is 1 (the bus is switched back to output). In the following idle cycle it is 0 again.
- R8: done goes high for exactly one cycle, 2*(SETUP_CYC+PULSE_CYC+HOLD_CYC) clock edges after the edge that accepted the request.
- R9: A request is accepted only when req is 1 and busy is 0, and busy is 1 from the next cycle. A req raised while busy has no effect. rd_data keeps its value from done until the next accepted request.
- R10: At most one of ale, !rd_n and !wr_n is active in any cycle, and ad_oe is never 1 while rd_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| page | output | PAGE_W | Masked page lines |
| hi_addr | output | 8 | High address byte |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench writes two locations that differ only in the page and reads them back. A design that dropped or mis-shifted the page field would return the second byte for both. A design that skipped the mask would miss the alias read through an address whose upper page bits are set, and a read of a never-written location shows whether a stale bus value leaks into rd_data. A req pulsed in the middle of a write is followed by a read of its target address through the normal interface, which catches a sequencer that restarts or queues. Per-access counts of ale, rd_n and wr_n cycles, the latency to done and the bus direction around the done cycle catch off-by-one errors in the phase timer and a missing turnaround.

// File: rtl/msb_pkg.sv
package msb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ALE,
        ST_AHOLD,
        ST_DSET,
        ST_STRB,
        ST_SHOLD,
        ST_DONE
    } msb_state_e;

    typedef struct packed {
        logic       we;
        logic [7:0] page;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] wdata;
    } msb_req_t;

    function automatic msb_req_t split_req(
        input logic        we,
        input logic [23:0] addr,
        input logic [7:0]  wdata,
        input logic [7:0]  mask
    );
        msb_req_t r;
        r.we    = we;
        r.page  = addr[23:16] & mask;
        r.hi    = addr[15:8];
        r.lo    = addr[7:0];
        r.wdata = wdata;
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/msb_phase_timer.sv
module msb_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R8: a running count steps down by one each cycle
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/msb_req_reg.sv
module msb_req_reg
    import msb_pkg::*;
#(
    parameter logic [7:0] MASK8 = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        we,
    input  logic [23:0] addr,
    input  logic [7:0]  wdata,
    output msb_req_t    cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (accept) begin
            cur <= split_req(we, addr, wdata, MASK8);
        end
    end
endmodule

// File: rtl/msb_seq.sv
module msb_seq
    import msb_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          is_write,
    input  logic          expired,
    output msb_state_e    state,
    output logic          tload,
    output logic [CW-1:0] tval,
    output logic          sample
);
    localparam logic [CW-1:0] LEN_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LEN_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LEN_HOLD  = CW'(HOLD_CYC - 1);

    msb_state_e nxt;

    always_comb begin
        nxt    = state;
        tload  = 1'b0;
        tval   = '0;
        sample = 1'b0;
        unique case (state)
            ST_IDLE: if (go) begin
                nxt = ST_ADDR; tload = 1'b1; tval = LEN_SETUP;
            end
            ST_ADDR: if (expired) begin
                nxt = ST_ALE; tload = 1'b1; tval = LEN_PULSE;
            end
            ST_ALE: if (expired) begin
                nxt = ST_AHOLD; tload = 1'b1; tval = LEN_HOLD;
            end
            ST_AHOLD: if (expired) begin
                nxt = ST_DSET; tload = 1'b1; tval = LEN_SETUP;
            end
            ST_DSET: if (expired) begin
                nxt = ST_STRB; tload = 1'b1; tval = LEN_PULSE;
            end
            ST_STRB: if (expired) begin
                nxt = ST_SHOLD; tload = 1'b1; tval = LEN_HOLD;
                sample = !is_write;
            end
            ST_SHOLD: if (expired) begin
                nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R9: a request in idle always starts the address phase
    a_r9_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && go) |=> (state == ST_ADDR));

    // R8: the done state lasts one cycle
    a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/mux_sram_master.sv
module mux_sram_master
    import msb_pkg::*;
#(
    parameter int              SETUP_CYC = 1,
    parameter int              PULSE_CYC = 1,
    parameter int              HOLD_CYC  = 1,
    parameter int              PAGE_W    = 8,
    parameter logic [PAGE_W-1:0] PAGE_MASK = PAGE_W'(8'h0F)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [23:0]       req_addr,
    input  logic [7:0]        req_wdata,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_data,
    output logic [PAGE_W-1:0] page,
    output logic [7:0]        hi_addr,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    input  logic [7:0]        ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int         MAXLEN = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int         CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
    localparam logic [7:0] MASK8  = 8'(PAGE_MASK);

    msb_state_e    state;
    msb_req_t      cur;
    logic          accept;
    logic          tload;
    logic [CW-1:0] tval;
    logic          expired;
    logic          sample;

    assign busy   = (state != ST_IDLE);
    assign accept = req && !busy;

    msb_req_reg #(.MASK8(MASK8)) u_req (
        .clk(clk), .rst(rst), .accept(accept), .we(req_we),
        .addr(req_addr), .wdata(req_wdata), .cur(cur)
    );

    msb_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(tload), .load_val(tval), .expired(expired)
    );

    msb_seq #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC(HOLD_CYC), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .go(accept), .is_write(cur.we),
        .expired(expired), .state(state), .tload(tload),
        .tval(tval), .sample(sample)
    );

    // Pin decode from registered state
    always_comb begin
        ale     = (state == ST_ALE);
        wr_n    = !(state == ST_STRB && cur.we);
        rd_n    = !(state == ST_STRB && !cur.we);
        done    = (state == ST_DONE);
        page    = busy ? cur.page[PAGE_W-1:0] : '0;
        hi_addr = busy ? cur.hi : 8'h00;
        ad_oe   = 1'b0;
        ad_out  = 8'h00;
        unique case (state)
            ST_ADDR, ST_ALE, ST_AHOLD: begin
                ad_oe = 1'b1; ad_out = cur.lo;
            end
            ST_DSET, ST_STRB, ST_SHOLD: begin
                ad_oe = cur.we; ad_out = cur.we ? cur.wdata : 8'h00;
            end
            ST_DONE: begin
                ad_oe = 1'b1; ad_out = cur.we ? cur.wdata : cur.lo;
            end
            default: begin
                ad_oe = 1'b0; ad_out = 8'h00;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= 8'h00;
        else if (sample) rd_data <= ad_in;
    end

    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_n && wr_n && !ale));

    a_r2_idle_bus: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ad_oe && hi_addr == 8'h00 && page == '0));

    a_r4_ale_driven: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> ad_oe);

    a_r5_wdata_held: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n)) |-> $stable(ad_out));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({ale, !rd_n, !wr_n}) <= 1);

    a_r10_no_fight: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

endmodule

// File: tb/mux_sram_master_tb_top.sv
module mux_sram_master_tb_top;
    localparam int S = 2;
    localparam int P = 2;
    localparam int H = 1;
    localparam int LAT = 2 * (S + P + H);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic busy, done, ad_oe, ale, rd_n, wr_n;
    logic [7:0] rd_data, page, hi_addr, ad_out, ad_in;

    always #2 clk = ~clk;

    mux_sram_master #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
                      .PAGE_W(8), .PAGE_MASK(8'h0F)) dut_i (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .page(page), .hi_addr(hi_addr), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // Behavioural latch and RAM
    logic [7:0]  lat_q = 8'h00;
    logic [7:0]  mem [int];
    logic [7:0]  ram_q;
    logic [23:0] key;
    logic        wr_prev = 1'b1, rd_prev = 1'b1;
    int          wcount = 0;
    logic [23:0] last_wkey = '0, last_rkey = '0;
    logic [7:0]  last_wdat = '0;
    int ale_cyc = 0, wr_cyc = 0, rd_cyc = 0, viol = 0;

    assign key = {page, hi_addr, lat_q};
    always_comb begin
        if (mem.exists(int'(key))) ram_q = mem[int'(key)];
        else                       ram_q = 8'hEE;
    end
    assign ad_in = ad_oe ? ad_out : (!rd_n ? ram_q : 8'hFF);

    always @(posedge clk) begin
        wr_prev <= wr_n;
        rd_prev <= rd_n;
        if (ale) lat_q <= ad_in;
        if (!wr_n) mem[int'(key)] = ad_in;
        if (!wr_n && wr_prev) begin
            wcount    <= wcount + 1;
            last_wkey <= key;
            last_wdat <= ad_in;
        end
        if (!rd_n && rd_prev) last_rkey <= key;
        if (req && !busy) begin
            ale_cyc <= 0; wr_cyc <= 0; rd_cyc <= 0;
        end else begin
            if (ale)   ale_cyc <= ale_cyc + 1;
            if (!wr_n) wr_cyc  <= wr_cyc + 1;
            if (!rd_n) rd_cyc  <= rd_cyc + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && (($countones({ale, !rd_n, !wr_n}) > 1) || (ad_oe && !rd_n)))
            viol++;
    end

    int total = 0, fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [23:0] a, input logic [7:0] d,
                          output int lat);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        chk("R9 busy after accept", busy, 1);
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [23:0] exp_key(input logic [23:0] a);
        return {a[23:16] & 8'h0F, a[15:0]};
    endfunction

    // {we, addr, wdata, expected read}
    localparam int NV = 10;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 24'h012345, 8'h5A, 8'h00},
        {1'b1, 24'h022345, 8'hC3, 8'h00},
        {1'b1, 24'h00FF00, 8'h81, 8'h00},
        {1'b1, 24'h370A0B, 8'h6E, 8'h00},
        {1'b0, 24'h012345, 8'h00, 8'h5A},
        {1'b0, 24'h022345, 8'h00, 8'hC3},
        {1'b0, 24'h00FF00, 8'h00, 8'h81},
        {1'b0, 24'h070A0B, 8'h00, 8'h6E},
        {1'b0, 24'h170A0B, 8'h00, 8'h6E},
        {1'b0, 24'h050000, 8'h00, 8'hEE}
    };

    initial begin
        int lat;
        int wc0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset wr_n", wr_n, 1);
        chk("R1 reset rd_n", rd_n, 1);
        chk("R1 reset ale", ale, 0);
        chk("R2 reset ad_oe", ad_oe, 0);
        chk("R2 reset hi_addr", hi_addr, 0);
        chk("R2 reset page", page, 0);
        chk("R8 reset done", done, 0);

        for (int i = 0; i < NV; i++) begin
            logic        we;
            logic [23:0] a;
            logic [7:0]  d, e;
            {we, a, d, e} = VEC[i];
            access(we, a, d, lat);
            chk("R8 latency", lat, LAT);
            chk("R7 bus driven at done", ad_oe, 1);
            chk("R4 ale width", ale_cyc, P);
            if (we) begin
                chk("R3 write location", last_wkey, exp_key(a));
                chk("R5 write data", last_wdat, d);
                chk("R5 wr_n width", wr_cyc, P);
            end else begin
                chk("R3 read location", last_rkey, exp_key(a));
                chk("R6 read data", rd_data, e);
                chk("R6 rd_n width", rd_cyc, P);
            end
            @(negedge clk);
            chk("R8 done one cycle", done, 0);
            chk("R7 bus released in idle", ad_oe, 0);
            chk("R2 idle hi_addr", hi_addr, 0);
            chk("R1 idle strobes", {ale, rd_n, wr_n}, 3'b011);
        end

        // R9: rd_data holds after done
        held = rd_data;
        repeat (5) @(negedge clk);
        chk("R9 rd_data held", rd_data, held);

        // R9: a req raised while busy is ignored
        wc0 = wcount;
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 24'h004444; req_wdata = 8'h11;
        @(negedge clk);
        req_addr = 24'h005555; req_wdata = 8'h99;
        repeat (2) @(negedge clk);
        req = 1'b0;
        lat = 2;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 single write during busy req", wcount - wc0, 1);
        chk("R9 first request kept", last_wkey, exp_key(24'h004444));
        @(negedge clk);
        access(1'b0, 24'h005555, 8'h00, lat);
        chk("R9 ignored target untouched", rd_data, 8'hEE);
        access(1'b0, 24'h004444, 8'h00, lat);
        chk("R9 accepted target written", rd_data, 8'h11);

        chk("R10 strobe exclusivity and no fight", viol, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule